// File: doc/BRIEF.md
# Constant-Tone Preamble Wakeup Detector

This block sits behind the data slicer of an on-off-keyed receiver and watches the recovered data bit. It tells a sleeping decoder or microcontroller that a transmission is probably starting. The idle line is low, so a transmitter announces itself with a long stretch of continuous carrier. The sliced bit stays high for that whole stretch. Noise seldom holds the line high for several milliseconds, so a long unbroken high run is a reliable sign of a real header.

The reference clock is divided down to a slow counting tick, 1/256 of the reference by default. A run-length counter counts ticks for as long as the synchronized data stays high. Any low sample clears the counter. When the counter reaches the configured number of ticks, 128 by default, the active-low wakeup output drops. It stays low until the header ends and the payload begins with its first low level. The counter then starts again from zero. A shutdown input disables the detector, clears its state and holds the output inactive.

Top module: `tone_wake_detect`

## Requirements
- R1: While `rst` is high at a clock edge, the synchronizer, the prescaler, the run-length counter and the wakeup flag all clear. `wake_n` reads 1 after that edge.
- R2: `data_in` passes through two flip-flops before it is used. A level applied before edge e reaches the detector at edge e+1. When the output reacts to a falling input, it changes after edge e+2.
- R3: The counting tick occurs on every PRESCALE-th clock edge. The prescaler restarts from zero when reset or shutdown is released. With data held high from release onward, the first tick falls on the PRESCALE-th edge after release.
- R4: `wake_n` is active low (0 = wakeup). It goes to 0 after the RUN_TICKS-th tick that is seen with the synchronized data continuously high. From a release with the tone already present, this happens at exactly RUN_TICKS*PRESCALE edges after release.
- R5: Any clock edge that samples the synchronized data low clears the run-length count. A single-cycle dip in the tone therefore delays the wakeup by a full new run.
- R6: Once `wake_n` is 0, it stays 0 for as long as the synchronized data stays high and shutdown stays low, however long that lasts.
- R7: After assertion, the first low of the synchronized data returns `wake_n` to 1 on that edge. The count restarts from zero, so a new wakeup needs a full RUN_TICKS ticks again.
- R8: While `shutdown` is high, `wake_n` is 1 after every edge, and the prescaler and counter are cleared. Data activity during shutdown has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| shutdown | input | 1 | Disables the detector and holds the flag inactive, active high |
| data_in | input | 1 | Raw sliced data bit from the demodulator, asynchronous |
| wake_n | output | 1 | Wakeup flag, low after a qualifying constant tone |

## Verification
The bench targets the exact count boundary. A counter that is off by one tick would drop `wake_n` one prescaler period early or late, and the directed runs from a clean release catch that shift exactly. A one-cycle dip just before the boundary is aimed at a design that fails to clear the count on a break, which would wake up too soon. The bench also checks the release latency through the synchronizer and re-arming after the payload starts. A design that keeps a stale count would wake again before a full new header. Shutdown is applied with the flag already low and with the data toggling. Random stretches of tone, gaps and shutdown pulses then cover the other prescaler phases against a reference model in the bench.

// File: rtl/tone_wake_detect.sv
module tone_wake_detect #(
  parameter int PRESCALE  = 256,
  parameter int RUN_TICKS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic shutdown,
  input  logic data_in,
  output logic wake_n
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int RW = (RUN_TICKS > 1) ? $clog2(RUN_TICKS) : 1;

  logic [1:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic [RW-1:0] run_q;
  logic          armed_q;
  logic          tone, tick, run_full;

  assign tone     = sync_q[1];
  assign tick     = (pre_q == PW'(PRESCALE - 1));
  assign run_full = (run_q == RW'(RUN_TICKS - 1));
  assign wake_n   = ~armed_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[0], data_in};
  end

  always_ff @(posedge clk) begin
    if (rst || shutdown) pre_q <= '0;
    else if (tick)       pre_q <= '0;
    else                 pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || shutdown) begin
      run_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q) begin
      run_q <= '0;
      if (!tone) armed_q <= 1'b0;
    end else if (!tone) begin
      run_q <= '0;
    end else if (tick) begin
      if (run_full) begin
        armed_q <= 1'b1;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tone_wake_checks.sv
module tone_wake_checks #(
  parameter int RW        = 7,
  parameter int RUN_TICKS = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          shutdown,
  input logic          tone,
  input logic          tick,
  input logic [RW-1:0] run_q,
  input logic          wake_n
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> wake_n);

  a_r8_shut_idle: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (wake_n && run_q == '0));

  a_r5_break_clears: assert property (@(posedge clk) disable iff (rst)
    !tone |=> run_q == '0);

  a_r4_fall_on_last_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(wake_n) |-> $past(tick && tone && run_q == RW'(RUN_TICKS - 1)));

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (!wake_n && tone && !shutdown) |=> !wake_n);

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (!wake_n && !tone) |=> (wake_n && run_q == '0));
endmodule

bind tone_wake_detect tone_wake_checks #(.RW(RW), .RUN_TICKS(RUN_TICKS)) u_checks (
  .clk(clk), .rst(rst), .shutdown(shutdown), .tone(tone),
  .tick(tick), .run_q(run_q), .wake_n(wake_n)
);

// File: tb/test_tone_wake_detect.sv
module test_tone_wake_detect;
  localparam int P = 8;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shutdown = 1'b0;
  logic data_in = 1'b0;
  logic wake_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;

  tone_wake_detect #(.PRESCALE(P), .RUN_TICKS(N)) i_tone_wake_detect (
    .clk(clk), .rst(rst), .shutdown(shutdown), .data_in(data_in), .wake_n(wake_n)
  );

  always #4 clk = ~clk;

  // reference model built from the requirements
  bit m_s1, m_s2, m_flag, m_flag_prev, m_shut;
  int m_pre, m_run;

  function automatic int next_pre(int pre);
    return (pre == P - 1) ? 0 : pre + 1;
  endfunction

  always @(posedge clk) begin
    started     <= 1'b1;
    cycles      <= cycles + 1;
    m_flag_prev <= m_flag;
    m_shut      <= shutdown;
    if (rst) begin
      m_s1 <= 1'b0; m_s2 <= 1'b0;
    end else begin
      m_s1 <= data_in; m_s2 <= m_s1;
    end
    if (rst || shutdown) begin
      m_pre <= 0; m_run <= 0; m_flag <= 1'b0;
    end else begin
      m_pre <= next_pre(m_pre);
      if (m_flag) begin
        m_run <= 0;
        if (!m_s2) m_flag <= 1'b0;
      end else if (!m_s2) begin
        m_run <= 0;
      end else if (m_pre == P - 1) begin
        if (m_run == N - 1) begin m_flag <= 1'b1; m_run <= 0; end
        else m_run <= m_run + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      string tag;
      if (m_shut) tag = "R8";
      else if (m_flag != m_flag_prev) tag = m_flag ? "R4" : "R7";
      else tag = m_flag ? "R6" : "R5";
      check(wake_n == !m_flag, tag, wake_n, !m_flag);
    end
    if (cycles > 200000) begin
      check(1'b0, "watchdog", cycles, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_to_wake(input string tag);
    int k = 0;
    for (int i = 1; i <= 2 * N * P; i++) begin
      @(negedge clk);
      if (wake_n == 1'b0) begin k = i; break; end
    end
    check(k == N * P, tag, k, N * P);
  endtask

  initial begin
    void'($urandom(20240611));
    step(3);
    check(wake_n == 1'b1, "R1", wake_n, 1);

    // R4: tone present from release, exact boundary
    data_in = 1'b1; rst = 1'b0;
    count_to_wake("R4");

    // R6: hold for a long stretch
    step(5 * N * P);
    check(wake_n == 1'b0, "R6", wake_n, 0);

    // R2/R7: payload starts
    data_in = 1'b0;
    step(1); check(wake_n == 1'b0, "R2", wake_n, 0);
    step(1); check(wake_n == 1'b0, "R2", wake_n, 0);
    step(1); check(wake_n == 1'b1, "R7", wake_n, 1);
    data_in = 1'b1;
    step((N - 1) * P);
    check(wake_n == 1'b1, "R7", wake_n, 1);
    step(2 * P + 4);
    check(wake_n == 1'b0, "R7", wake_n, 0);

    // R5: one-cycle dip just before the boundary
    rst = 1'b1; step(2);
    rst = 1'b0;
    step(N * P - 10);
    data_in = 1'b0; step(1); data_in = 1'b1;
    step(14);
    check(wake_n == 1'b1, "R5", wake_n, 1);
    step(N * P);
    check(wake_n == 1'b0, "R5", wake_n, 0);

    // R8: shutdown while awake, data toggling
    shutdown = 1'b1;
    step(1); check(wake_n == 1'b1, "R8", wake_n, 1);
    for (int i = 0; i < 40; i++) begin
      data_in = $urandom_range(0, 1);
      step(1);
      check(wake_n == 1'b1, "R8", wake_n, 1);
    end
    data_in = 1'b1; step(3);

    // R3: prescaler restarts on release of shutdown
    shutdown = 1'b0;
    count_to_wake("R3");

    // random stretches of tone, gaps and shutdown pulses
    for (int s = 0; s < 300; s++) begin
      int kind = $urandom_range(0, 9);
      if (kind == 0) begin
        shutdown = 1'b1; step($urandom_range(1, 12)); shutdown = 1'b0;
      end else if (kind < 4) begin
        data_in = 1'b1; step($urandom_range(N * P - 2 * P, N * P + 3 * P));
      end else if (kind < 7) begin
        data_in = 1'b0; step($urandom_range(1, 6));
      end else begin
        data_in = 1'b1; step($urandom_range(1, 3 * P));
      end
    end

    step(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule